// File: doc/BRIEF.md
# Line Alarm Interrupt Status Registers

This block is a small register bank that collects alarm conditions from a line interface and presents them to a host over a simple synchronous read/write bus. It watches four level alarms: loss of signal, alarm indication signal, pattern sync and driver-failure-open. It also takes two single-cycle event pulses, for overflow and underflow of the elastic store. Three views are offered. The first is a live condition register. The second is an event register that records level changes and latches elastic-store events. The third is a control register, in which writing a 1 both acknowledges an event and keeps it masked.

The host reads the live view to see the present line state. It reads the event view to learn what happened since its last acknowledgement. Reading the event view drops the two elastic-store events. The level-change events are dropped only through the control register. A single active-high interrupt line tells the host that at least one unmasked event is pending.

Top module: `lai_regbank`

## Requirements
- R1: The register is selected by address bits 6..1, and bits 7 and 0 are ignored. Offset 0x13 is the control register, 0x14 the event register and 0x15 the live register. Any other offset reads 0.
- R2: The live register reads the inputs combinationally: bit 0 is loss of signal, bit 2 is alarm indication and bit 3 is pattern sync.
- R3: Event bits 0, 2, 3 and 5 (loss of signal, alarm indication, pattern sync, driver-failure-open) set at the clock edge where their input differs from the value it had at the previous edge. They then stay set until cleared through the control register.
- R4: The pattern-sync event bit records only gain and loss of sync. While the sync input holds a steady level, the bit does not set.
- R5: Event bit 6 latches an elastic-store overflow pulse and event bit 7 latches an underflow pulse. Each stays set until cleared.
- R6: A read of the event register (bus_rd at offset 0x14) clears bits 6 and 7 at that edge and leaves bits 0, 2, 3 and 5 unchanged. A pulse arriving in the same cycle as the read leaves its bit set.
- R7: Control register bits 0, 2, 3, 5, 6 and 7 pair with the event bits at the same positions. Writing 1 clears the event at that edge and holds it clear while the bit stays 1. Writing 0 re-enables the event. The control register reads back what was written.
- R8: irq_o is high exactly when some event bit is set, and no masked source can raise it.
- R9: Bits 1 and 4 read as 0 in every register. Writes to offsets 0x14 and 0x15 have no effect.
- R10: After reset, the event bits, the control bits and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address; bits 6..1 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a strobe at the event register clears the elastic-store bits |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| los_i | input | 1 | Loss-of-signal level |
| ais_i | input | 1 | Alarm indication level |
| sync_i | input | 1 | Pattern sync level |
| dfmo_i | input | 1 | Driver-failure-open level |
| es_ovf_pulse_i | input | 1 | Elastic-store overflow event pulse |
| es_unf_pulse_i | input | 1 | Elastic-store underflow event pulse |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The assertions take three things for granted. The alarm inputs are synchronous to clk. All inputs are held low during reset, so the first change comparison after reset starts from zero. bus_rd and bus_wr are never high together. The bench drives every input at the falling edge and returns every input to 0 before each reset. Its bus tasks raise only one strobe at a time. It creates same-cycle read and pulse collisions only through a dedicated scenario that still keeps the two strobes apart.

// File: rtl/lai_pkg.sv
package lai_pkg;
    localparam int OFF_W  = 6;
    localparam int ADDR_W = OFF_W + 2;
    localparam int REG_W  = 8;
    localparam int N_LVL  = 4;

    localparam int B_LOS  = 0;
    localparam int B_AIS  = 2;
    localparam int B_SYNC = 3;
    localparam int B_DFMO = 5;
    localparam int B_OVF  = 6;
    localparam int B_UNF  = 7;

    localparam logic [REG_W-1:0] STICKY_BITS = 8'hC0;
    localparam logic [REG_W-1:0] CTRL_BITS   = 8'hED;

    localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h13;
    localparam logic [OFF_W-1:0] OFF_EVT   = 6'h14;
    localparam logic [OFF_W-1:0] OFF_LIVE  = 6'h15;

    typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_EVT, SEL_LIVE} lai_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] flags;
        logic [REG_W-1:0] mask;
    } lai_state_t;
endpackage

// File: rtl/lai_addr_dec.sv
module lai_addr_dec
    import lai_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    output lai_sel_e         sel_o
);
    always_comb begin
        unique case (off_i)
            OFF_CTRL: sel_o = SEL_CTRL;
            OFF_EVT:  sel_o = SEL_EVT;
            OFF_LIVE: sel_o = SEL_LIVE;
            default:  sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/lai_change_det.sv
module lai_change_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] changed_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= level_i[g];
        end
        assign changed_o[g] = level_i[g] ^ prev_q;
    end
endmodule

// File: rtl/lai_regbank.sv
module lai_regbank
    import lai_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              los_i,
    input  logic              ais_i,
    input  logic              sync_i,
    input  logic              dfmo_i,
    input  logic              es_ovf_pulse_i,
    input  logic              es_unf_pulse_i,
    output logic              irq_o
);
    lai_state_t        st_d, st_q;
    lai_sel_e          sel;
    logic [N_LVL-1:0]  lvl, chg;
    logic [REG_W-1:0]  live_vec, set_vec, clr_vec, mask_next;
    logic [REG_W-1:0]  flags_q, mask_q;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{bus_addr[ADDR_W-1], bus_addr[0]};

    lai_addr_dec u_dec (
        .off_i (bus_addr[OFF_W:1]),
        .sel_o (sel)
    );

    assign lvl = {dfmo_i, sync_i, ais_i, los_i};

    lai_change_det #(.N(N_LVL)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (lvl),
        .changed_o (chg)
    );

    always_comb begin
        live_vec         = '0;
        live_vec[B_LOS]  = los_i;
        live_vec[B_AIS]  = ais_i;
        live_vec[B_SYNC] = sync_i;

        set_vec          = '0;
        set_vec[B_LOS]   = chg[0];
        set_vec[B_AIS]   = chg[1];
        set_vec[B_SYNC]  = chg[2];
        set_vec[B_DFMO]  = chg[3];
        set_vec[B_OVF]   = es_ovf_pulse_i;
        set_vec[B_UNF]   = es_unf_pulse_i;

        clr_vec = '0;
        if (bus_rd && sel == SEL_EVT) clr_vec = STICKY_BITS;

        mask_next = st_q.mask;
        if (bus_wr && sel == SEL_CTRL) mask_next = bus_wdata & CTRL_BITS;

        st_d       = st_q;
        st_d.mask  = mask_next;
        st_d.flags = ((st_q.flags & ~clr_vec) | set_vec) & ~mask_next & CTRL_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign mask_q  = st_q.mask;

    always_comb begin
        unique case (sel)
            SEL_CTRL: bus_rdata = mask_q;
            SEL_EVT:  bus_rdata = flags_q;
            SEL_LIVE: bus_rdata = live_vec;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = |(flags_q & ~mask_q);
endmodule

// File: rtl/lai_regbank_chk.sv
module lai_regbank_chk
    import lai_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              los_i,
    input logic              es_ovf_pulse_i,
    input logic              es_unf_pulse_i,
    input logic              irq_o,
    input logic [REG_W-1:0]  flags_q,
    input logic [REG_W-1:0]  mask_q
);
    logic [OFF_W-1:0] off;
    logic             wr_ctrl, rd_evt;
    logic             unused_chk_bits;

    assign off             = bus_addr[OFF_W:1];
    assign wr_ctrl         = bus_wr && off == OFF_CTRL;
    assign rd_evt          = bus_rd && off == OFF_EVT;
    assign unused_chk_bits = ^{bus_addr[ADDR_W-1], bus_addr[0]};

    AST_CTRL_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((flags_q & $past(bus_wdata) & CTRL_BITS) == '0)); // R7

    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & CTRL_BITS) == CTRL_BITS) |-> !irq_o); // R8

    AST_ES_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (es_ovf_pulse_i && !mask_q[B_OVF] && !wr_ctrl) |=> flags_q[B_OVF]); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !es_ovf_pulse_i && !es_unf_pulse_i) |=> (flags_q[B_UNF:B_OVF] == 2'b00)); // R6

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[B_OVF] && !rd_evt && !wr_ctrl) |=> flags_q[B_OVF]); // R5

    AST_LOS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[B_LOS] && !wr_ctrl && (los_i != $past(los_i))) |=> flags_q[B_LOS]); // R3

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rdata[1] && !bus_rdata[4])); // R9

    AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off != OFF_CTRL) |=> $stable(mask_q)); // R9

    AST_LIVE_LOS: assert property (@(posedge clk) disable iff (!rst_n)
        (off == OFF_LIVE) |-> (bus_rdata[B_LOS] == los_i)); // R2
endmodule

bind lai_regbank lai_regbank_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .los_i          (los_i),
    .es_ovf_pulse_i (es_ovf_pulse_i),
    .es_unf_pulse_i (es_unf_pulse_i),
    .irq_o          (irq_o),
    .flags_q        (flags_q),
    .mask_q         (mask_q)
);

// File: tb/tb_lai_regbank.sv
`timescale 1ns/1ps
module tb_lai_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       los_i = 0, ais_i = 0, sync_i = 0, dfmo_i = 0;
    logic       es_ovf_pulse_i = 0, es_unf_pulse_i = 0;
    logic       irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [7:0] A_CTRL = 8'h26, A_EVT = 8'h28, A_LIVE = 8'h2A;

    always #2.5 clk = ~clk;

    lai_regbank dut (.*);

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        {los_i, ais_i, sync_i, dfmo_i, es_ovf_pulse_i, es_unf_pulse_i} = '0;
        bus_wr = 0; bus_rd = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        peek(A_CTRL, v); check(v, 8'h00, "R10", "control after reset");
        peek(A_EVT, v);  check(v, 8'h00, "R10", "events after reset");
        check({7'b0, irq_o}, 8'h00, "R10", "irq after reset");
    endtask

    task automatic t_decode();
        logic [7:0] v;
        do_reset();
        los_i = 1; sync_i = 1;
        peek(A_LIVE, v); check(v, 8'h09, "R2", "live los+sync");
        peek(8'h2B, v);  check(v, 8'h09, "R1", "alias addr bit0");
        peek(8'hAA, v);  check(v, 8'h09, "R1", "alias addr bit7");
        peek(8'h00, v);  check(v, 8'h00, "R1", "unused offset");
        peek(8'hA9, v);  check(v, 8'h09, "R1", "event alias 0xA9");
        ais_i = 1; dfmo_i = 1;
        peek(A_LIVE, v); check(v, 8'h0D, "R9", "live reserved bits zero");
    endtask

    task automatic t_los();
        logic [7:0] v;
        do_reset();
        step(); los_i = 1; step();
        peek(A_EVT, v); check(v, 8'h01, "R3", "los rise flagged");
        check({7'b0, irq_o}, 8'h01, "R8", "irq on los change");
        repeat (5) step();
        peek(A_EVT, v); check(v, 8'h01, "R3", "los flag held");
        wr(A_CTRL, 8'h01);
        peek(A_EVT, v); check(v, 8'h00, "R7", "los cleared by write");
        check({7'b0, irq_o}, 8'h00, "R8", "irq low after clear");
        los_i = 0; step(); step();
        peek(A_EVT, v); check(v, 8'h00, "R7", "masked los change held clear");
        check({7'b0, irq_o}, 8'h00, "R8", "masked los no irq");
        peek(A_CTRL, v); check(v, 8'h01, "R7", "control readback");
        wr(A_CTRL, 8'h00);
        los_i = 1; step();
        peek(A_EVT, v); check(v, 8'h01, "R7", "los re-enabled");
    endtask

    task automatic t_sync();
        logic [7:0] v;
        do_reset();
        step(); sync_i = 1; step();
        peek(A_EVT, v); check(v, 8'h08, "R4", "sync gain flagged");
        wr(A_CTRL, 8'h08); wr(A_CTRL, 8'h00);
        repeat (20) step();
        peek(A_EVT, v); check(v, 8'h00, "R4", "steady sync not flagged");
        sync_i = 0; step();
        peek(A_EVT, v); check(v, 8'h08, "R4", "sync loss flagged");
    endtask

    task automatic t_ais_dfmo();
        logic [7:0] v;
        do_reset();
        step(); ais_i = 1; dfmo_i = 1; step();
        peek(A_EVT, v); check(v, 8'h24, "R3", "ais and dfmo flagged");
        wr(A_CTRL, 8'h20);
        peek(A_EVT, v); check(v, 8'h04, "R7", "only dfmo cleared");
    endtask

    task automatic t_es();
        logic [7:0] v;
        do_reset();
        step(); es_ovf_pulse_i = 1; step(); es_ovf_pulse_i = 0;
        repeat (4) step();
        peek(A_EVT, v); check(v, 8'h40, "R5", "overflow sticky");
        check({7'b0, irq_o}, 8'h01, "R8", "irq on overflow");
        los_i = 1; es_unf_pulse_i = 1; step(); es_unf_pulse_i = 0;
        rd(A_EVT, v); check(v, 8'hC1, "R5", "read shows sticky+los");
        peek(A_EVT, v); check(v, 8'h01, "R6", "read clears sticky only");
    endtask

    task automatic t_setwins();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        bus_addr = A_EVT; bus_rd = 1; es_unf_pulse_i = 1;
        @(negedge clk);
        bus_rd = 0; es_unf_pulse_i = 0;
        peek(A_EVT, v); check(v, 8'h80, "R6", "pulse during read kept");
    endtask

    task automatic t_mask_ro();
        logic [7:0] v;
        do_reset();
        wr(A_CTRL, 8'h40);
        step(); es_ovf_pulse_i = 1; step(); es_ovf_pulse_i = 0;
        peek(A_EVT, v); check(v, 8'h00, "R7", "masked overflow not latched");
        check({7'b0, irq_o}, 8'h00, "R8", "masked overflow no irq");
        wr(A_CTRL, 8'hFF);
        peek(A_CTRL, v); check(v, 8'hED, "R9", "control reserved bits zero");
        wr(A_EVT, 8'h00); wr(A_LIVE, 8'h00);
        peek(A_CTRL, v); check(v, 8'hED, "R9", "read-only writes ignored");
        wr(A_CTRL, 8'h00);
        wr(A_EVT, 8'hFF);
        peek(A_EVT, v); check(v, 8'h00, "R9", "event write ignored");
    endtask

    initial begin
        t_reset();
        t_decode();
        t_los();
        t_sync();
        t_ais_dfmo();
        t_es();
        t_setwins();
        t_mask_ro();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule